// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block sits between a host CPU bus and an embedded keyboard controller and carries bytes in both directions. The controller deposits a byte in an outbound slot that the host collects. The host deposits a byte in an inbound slot, through either a data port or a command port, and the controller collects it. Each slot keeps a full flag that the writes and reads set and clear on their own, so neither side needs a separate handshake.

The inbound side records whether its byte came through the command port. It raises an overrun flag when the host writes over a byte the controller has not yet read. The inbound full flag doubles as the controller's interrupt source. Every host write also gives a one-cycle wake pulse that can bring a halted or stopped controller back to life. The outbound side raises a host interrupt when the controller loads a byte while the interrupt enable is high. A host read drops that interrupt again.

Each slot is a two-state machine with the states SLOT_EMPTY and SLOT_FULL. The transitions are FILL (from empty to full on a write), CONSUME (from full to empty on a read with no write in the same cycle) and REFILL (from full back to full on a write, with the byte replaced). All outputs are registered, so every effect shows in the cycle after the strobe.

Top module: `kbm_host_mailbox`

## Requirements
- R1: After reset, host_ibf, host_obf, host_irq, ctl_ovr and ctl_wake are all 0.
- R2: A host_wr_data strobe does three things in the next cycle: host_ibf and ctl_ibf_irq go to 1, ctl_rdata holds the written byte, and ctl_is_cmd is 0.
- R3: A host_wr_cmd strobe does three things in the next cycle: host_ibf goes to 1, ctl_rdata holds the byte, and ctl_is_cmd is 1.
- R4: A ctl_rd strobe with no host write in the same cycle clears host_ibf and ctl_ibf_irq in the next cycle (CONSUME).
- R5: A ctl_wr strobe sets host_obf in the next cycle, and host_rdata then holds the written byte.
- R6: ctl_wr with kirq_en at 1 sets host_irq in the next cycle. ctl_wr with kirq_en at 0 leaves host_irq unchanged.
- R7: A host_rd strobe with no ctl_wr in the same cycle clears both host_obf and host_irq in the next cycle. host_irq is never 1 while host_obf is 0.
- R8: A host write while host_ibf is 1 and ctl_rd is 0 replaces the byte and sets ctl_ovr. ctl_ovr stays at 1 until a ctl_ovr_clr strobe clears it.
- R9: When a set and a clear reach the same flag in the same cycle, the set wins. This covers host write with ctl_rd (ibf), ctl_wr with host_rd (obf, and irq when enabled), and overrun with ctl_ovr_clr (ovr).
- R10: ctl_wake is 1 for exactly the cycle after each host write and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_data | input | 1 | Host write strobe, data port |
| host_wr_cmd | input | 1 | Host write strobe, command port |
| host_wdata | input | DW | Host write byte |
| host_rd | input | 1 | Host read strobe for the outbound slot |
| host_rdata | output | DW | Outbound slot byte |
| host_obf | output | 1 | Outbound slot full |
| host_ibf | output | 1 | Inbound slot full |
| host_irq | output | 1 | Host keyboard interrupt |
| kirq_en | input | 1 | Host interrupt enable |
| ctl_wr | input | 1 | Controller write strobe for the outbound slot |
| ctl_wdata | input | DW | Controller write byte |
| ctl_rd | input | 1 | Controller read strobe for the inbound slot |
| ctl_rdata | output | DW | Inbound slot byte |
| ctl_is_cmd | output | 1 | Inbound byte came through the command port |
| ctl_ibf_irq | output | 1 | Controller input-buffer interrupt |
| ctl_wake | output | 1 | Wake pulse on a host write |
| ctl_ovr | output | 1 | Sticky inbound overrun flag |
| ctl_ovr_clr | input | 1 | Clears the overrun flag |

## Verification
The assertions assume that host_wr_data and host_wr_cmd are never high in the same cycle, since a byte enters through one port at a time. A checker property guards this assumption. The bench drives each strobe alone or in the chosen collision pairs and never asserts both host write strobes together. Every strobe is held for exactly one cycle, and inputs change only at the falling edge.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/kbm_in_slot.sv
module kbm_in_slot
    import kbm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          ovr_clr,
    output logic          full,
    output logic [DW-1:0] rdata,
    output logic          is_cmd,
    output logic          ovr,
    output logic          wake
);
    slot_e         state_q, state_d;
    logic [DW-1:0] data_q;
    logic          cmd_q, ovr_q, wake_q;
    logic          host_wr;

    assign host_wr = wr_data | wr_cmd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: FILL, CONSUME, REFILL (a write beats a read)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (host_wr) state_d = SLOT_FULL;
            SLOT_FULL:  if (!host_wr && rd) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // datapath and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= 1'b0;
            ovr_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= host_wr;
            if (host_wr) begin
                data_q <= wdata;
                cmd_q  <= wr_cmd;
            end
            if (host_wr && state_q == SLOT_FULL && !rd) ovr_q <= 1'b1;
            else if (ovr_clr)                           ovr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        full   = (state_q == SLOT_FULL);
        rdata  = data_q;
        is_cmd = cmd_q;
        ovr    = ovr_q;
        wake   = wake_q;
    end
endmodule

// File: rtl/kbm_out_slot.sv
module kbm_out_slot
    import kbm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          irq_en,
    input  logic          rd,
    output logic          full,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    slot_e         state_q, state_d;
    logic [DW-1:0] data_q;
    logic          irq_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: FILL, CONSUME, REFILL (a write beats a read)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr) state_d = SLOT_FULL;
            SLOT_FULL:  if (!wr && rd) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr) data_q <= wdata;
            if (wr && irq_en) irq_q <= 1'b1;
            else if (rd)      irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        full  = (state_q == SLOT_FULL);
        rdata = data_q;
        irq   = irq_q;
    end
endmodule

// File: rtl/kbm_host_mailbox.sv
module kbm_host_mailbox #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_data,
    input  logic          host_wr_cmd,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic          host_obf,
    output logic          host_ibf,
    output logic          host_irq,
    input  logic          kirq_en,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          ctl_rd,
    output logic [DW-1:0] ctl_rdata,
    output logic          ctl_is_cmd,
    output logic          ctl_ibf_irq,
    output logic          ctl_wake,
    output logic          ctl_ovr,
    input  logic          ctl_ovr_clr
);
    logic ib_full;

    kbm_in_slot #(.DW(DW)) i_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (host_wr_data),
        .wr_cmd  (host_wr_cmd),
        .wdata   (host_wdata),
        .rd      (ctl_rd),
        .ovr_clr (ctl_ovr_clr),
        .full    (ib_full),
        .rdata   (ctl_rdata),
        .is_cmd  (ctl_is_cmd),
        .ovr     (ctl_ovr),
        .wake    (ctl_wake)
    );

    kbm_out_slot #(.DW(DW)) i_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .irq_en (kirq_en),
        .rd     (host_rd),
        .full   (host_obf),
        .rdata  (host_rdata),
        .irq    (host_irq)
    );

    assign host_ibf    = ib_full;
    assign ctl_ibf_irq = ib_full;
endmodule

// File: rtl/kbm_chk.sv
module kbm_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr_data,
    input logic host_wr_cmd,
    input logic host_rd,
    input logic host_obf,
    input logic host_ibf,
    input logic host_irq,
    input logic kirq_en,
    input logic ctl_wr,
    input logic ctl_rd,
    input logic ctl_is_cmd,
    input logic ctl_ibf_irq,
    input logic ctl_wake,
    input logic ctl_ovr,
    input logic ctl_ovr_clr
);
    logic hw;
    assign hw = host_wr_data | host_wr_cmd;

    AST_ONE_HOST_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_data && host_wr_cmd));
    AST_DATA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_data |=> host_ibf && ctl_ibf_irq && !ctl_is_cmd); // R2
    AST_CMD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_cmd |=> host_ibf && ctl_is_cmd); // R3
    AST_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd && !hw |=> !host_ibf && !ctl_ibf_irq); // R4
    AST_OBF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> host_obf); // R5
    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && kirq_en |=> host_irq); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !kirq_en && !host_irq |=> !host_irq); // R6
    AST_HOST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !ctl_wr |=> !host_obf && !host_irq); // R7
    AST_IRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> host_obf); // R7
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hw && host_ibf && !ctl_rd |=> ctl_ovr); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ovr && !ctl_ovr_clr |=> ctl_ovr); // R8
    AST_SET_WINS_IB: assert property (@(posedge clk) disable iff (!rst_n)
        hw && ctl_rd |=> host_ibf); // R9
    AST_SET_WINS_OB: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && host_rd |=> host_obf); // R9
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hw |=> ctl_wake); // R10
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hw |=> !ctl_wake); // R10
endmodule

bind kbm_host_mailbox kbm_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_data (host_wr_data),
    .host_wr_cmd  (host_wr_cmd),
    .host_rd      (host_rd),
    .host_obf     (host_obf),
    .host_ibf     (host_ibf),
    .host_irq     (host_irq),
    .kirq_en      (kirq_en),
    .ctl_wr       (ctl_wr),
    .ctl_rd       (ctl_rd),
    .ctl_is_cmd   (ctl_is_cmd),
    .ctl_ibf_irq  (ctl_ibf_irq),
    .ctl_wake     (ctl_wake),
    .ctl_ovr      (ctl_ovr),
    .ctl_ovr_clr  (ctl_ovr_clr)
);

// File: tb/test_kbm_host_mailbox.sv
module test_kbm_host_mailbox;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_data = 1'b0, host_wr_cmd = 1'b0, host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0, ctl_wdata = '0;
    logic          kirq_en = 1'b0, ctl_wr = 1'b0, ctl_rd = 1'b0, ctl_ovr_clr = 1'b0;
    logic [DW-1:0] host_rdata, ctl_rdata;
    logic          host_obf, host_ibf, host_irq, ctl_is_cmd, ctl_ibf_irq, ctl_wake, ctl_ovr;

    always #4 clk = ~clk;  // 125 MHz

    kbm_host_mailbox #(.DW(DW)) i_kbm_host_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_obf(host_obf),
        .host_ibf(host_ibf), .host_irq(host_irq), .kirq_en(kirq_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata),
        .ctl_is_cmd(ctl_is_cmd), .ctl_ibf_irq(ctl_ibf_irq), .ctl_wake(ctl_wake),
        .ctl_ovr(ctl_ovr), .ctl_ovr_clr(ctl_ovr_clr)
    );

    typedef struct {
        string         req;
        int            due;
        logic          ibf, obf, irq, ovr, cmd, wake;
        logic [DW-1:0] cdata, hdata;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    // requirement-level model
    logic          m_ibf = 0, m_obf = 0, m_irq = 0, m_ovr = 0, m_cmd = 0, m_wake = 0;
    logic [DW-1:0] m_cdata = '0, m_hdata = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(string req);
        exp_t e;
        e.req = req; e.due = cyc + 1;
        e.ibf = m_ibf; e.obf = m_obf; e.irq = m_irq; e.ovr = m_ovr;
        e.cmd = m_cmd; e.wake = m_wake; e.cdata = m_cdata; e.hdata = m_hdata;
        q.push_back(e);
    endtask

    // driver: one cycle of stimulus, model update, expectation pushed
    task automatic step(input logic wd, input logic wc, input logic [DW-1:0] hb,
                        input logic hrd, input logic cw, input logic [DW-1:0] cb,
                        input logic en, input logic crd, input logic oclr, input string req);
        logic hw;
        @(negedge clk);
        host_wr_data = wd; host_wr_cmd = wc; host_wdata = hb; host_rd = hrd;
        ctl_wr = cw; ctl_wdata = cb; kirq_en = en; ctl_rd = crd; ctl_ovr_clr = oclr;
        hw = wd | wc;
        m_ovr  = (hw && m_ibf && !crd) ? 1'b1 : (oclr ? 1'b0 : m_ovr);
        m_ibf  = hw ? 1'b1 : (crd ? 1'b0 : m_ibf);
        if (hw) begin m_cdata = hb; m_cmd = wc; end
        m_irq  = (cw && en) ? 1'b1 : (hrd ? 1'b0 : m_irq);
        m_obf  = cw ? 1'b1 : (hrd ? 1'b0 : m_obf);
        if (cw) m_hdata = cb;
        m_wake = hw;
        push(req);
    endtask

    task automatic idle(input string req);
        step(0, 0, 8'h00, 0, 0, 8'h00, kirq_en, 0, 0, req);
    endtask

    task automatic cmp(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // monitor: pops expectations when due, compares all outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                cmp(e.req, "host_ibf",    host_ibf,    e.ibf);
                cmp(e.req, "ctl_ibf_irq", ctl_ibf_irq, e.ibf);
                cmp(e.req, "host_obf",    host_obf,    e.obf);
                cmp(e.req, "host_irq",    host_irq,    e.irq);
                cmp(e.req, "ctl_ovr",     ctl_ovr,     e.ovr);
                cmp(e.req, "ctl_is_cmd",  ctl_is_cmd,  e.cmd);
                cmp(e.req, "ctl_wake",    ctl_wake,    e.wake);
                cmp(e.req, "ctl_rdata",   ctl_rdata,   e.cdata);
                cmp(e.req, "host_rdata",  host_rdata,  e.hdata);
            end
        end
    end

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset state");
        idle("R1 idle after reset");

        step(1, 0, 8'h5A, 0, 0, 8'h00, 0, 0, 0, "R2 data-port write");
        idle("R10 wake drops");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, "R4 controller consume");
        step(0, 1, 8'hD4, 0, 0, 8'h00, 0, 0, 0, "R3 command-port write");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, "R4 consume command");
        for (int i = 0; i < 4; i++) begin
            step(i[0], ~i[0], 8'h30 + 8'(i * 37), 0, 0, 8'h00, 0, 0, 0, "R2 R3 byte pattern");
            step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, "R4 drain pattern");
        end

        step(1, 0, 8'h11, 0, 0, 8'h00, 0, 0, 0, "R2 fill before overrun");
        step(0, 1, 8'h22, 0, 0, 8'h00, 0, 0, 0, "R8 overwrite sets overrun");
        idle("R8 overrun sticky");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, 1, "R8 overrun cleared");
        step(1, 0, 8'h33, 0, 0, 8'h00, 0, 0, 1, "R9 overrun set beats clear");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 0, 1, "R8 clear again");
        step(1, 0, 8'h44, 0, 0, 8'h00, 0, 1, 0, "R9 write beats read, no overrun");
        step(0, 0, 8'h00, 0, 0, 8'h00, 0, 1, 0, "R4 consume after collision");

        step(0, 0, 8'h00, 0, 1, 8'hA5, 1, 0, 0, "R5 R6 controller write enabled");
        step(0, 0, 8'h00, 1, 0, 8'h00, 1, 0, 0, "R7 host read clears obf and irq");
        step(0, 0, 8'h00, 0, 1, 8'h3C, 0, 0, 0, "R6 write with irq disabled");
        idle("R6 irq stays low");
        step(0, 0, 8'h00, 1, 0, 8'h00, 0, 0, 0, "R7 host read clears obf");
        step(0, 0, 8'h00, 0, 1, 8'h77, 1, 0, 0, "R5 fill for collision");
        step(0, 0, 8'h00, 1, 1, 8'h88, 1, 0, 0, "R9 controller write beats host read");
        step(0, 0, 8'h00, 0, 1, 8'h99, 0, 0, 0, "R6 disabled write keeps pending irq");
        step(0, 0, 8'h00, 1, 0, 8'h00, 0, 0, 0, "R7 final host read");
        idle("R10 no wake without host write");
        idle("R10 quiet");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule